// File: doc/BRIEF.md
# MII Packet Timestamp Inserter

This block sits on the nibble-wide media-independent interface between an Ethernet MAC and a PHY and carries two independent lanes: transmit (MAC toward PHY) and receive (PHY toward MAC). Every nibble of every frame passes through a fixed-length delay line. While a frame streams in, the lane reads its type field. If the type equals the configured clock-synchronization value and the frame is long enough, the lane writes a stamp into a fixed payload window as the frame leaves. The stamp holds the local time and the local accuracy, both captured when the start-of-frame delimiter was seen. The lane also replaces the frame check sequence with a freshly computed CRC-32, so the rewritten frame is still valid on the wire.

Any other frame leaves bit-for-bit unchanged. Every frame, stamped or not, takes the same number of clock cycles to cross the block. A network node can therefore exchange synchronization frames that carry time taken right at the physical interface, and the timing of ordinary traffic is not disturbed. Both lanes run on one clock. Frames are separated by at least 24 idle cycles, which is the normal Ethernet inter-frame gap.

Top module: `mii_stamp_inserter`

## Requirements
- R1: While reset is asserted, and after it is released with idle inputs, both output enables are 0 and both output nibbles are 0.
- R2: The transmit lane (mac_tx_* to phy_tx_*) and the receive lane (phy_rx_* to mac_rx_*) each apply R3 to R10 to their own frames, and a frame on one lane produces no activity on the other lane.
- R3: Nibbles arrive least-significant first. The first 0xD nibble after the enable rises is the delimiter, and the nibble after it is frame byte 0. A frame is a synchronization frame when frame bytes 12 and 13 (high byte first) equal sync_type.
- R4: In a stamped frame, bytes 16 to 21 carry the 48-bit word {local_acc, local_time}. These are the values present in the cycle the delimiter nibble is presented. Byte 16+b holds word bits [8b+7:8b].
- R5: In a stamped frame, the preamble, the delimiter and every byte outside the stamp window and the last four bytes are forwarded unchanged.
- R6: In a stamped frame, the last four bytes are replaced by the CRC-32 of the rewritten frame from byte 0 up to the check sequence. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. It is sent least-significant byte first.
- R7: A frame whose type differs from sync_type leaves unchanged, including an original check sequence that is wrong.
- R8: A matching frame shorter than 26 bytes, counted from byte 0 through its check sequence, leaves unchanged. A matching frame of exactly 26 bytes is stamped.
- R9: Every output nibble and its enable appear exactly 23 clock cycles after the input nibble is presented, whether or not the frame is stamped.
- R10: A change of sync_type between frames takes effect from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_type | input | 16 | Type value that marks a synchronization frame |
| local_time | input | 32 | Current local time |
| local_acc | input | 16 | Current local accuracy bound |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| phy_tx_en | output | 1 | Transmit enable toward the PHY |
| phy_txd | output | 4 | Transmit nibble toward the PHY |
| phy_rx_dv | input | 1 | Receive data valid from the PHY |
| phy_rxd | input | 4 | Receive nibble from the PHY |
| mac_rx_dv | output | 1 | Receive data valid toward the MAC |
| mac_rxd | output | 4 | Receive nibble toward the MAC |

## Verification
A wrong type match or length decision shows up at the output as six wrong bytes starting at frame byte 16. This happens about 23 cycles after those bytes enter the lane, followed by a check sequence that no longer matches. A CRC register that is corrupted anywhere in the frame shows up only in the final eight output nibbles. A drift in the delay line or the delimiter tracking moves the first output nibble away from cycle 23, or shifts the frame so that the nibble-by-nibble comparison breaks. The bench therefore compares whole frames nibble by nibble, split into stamp window, check sequence and the rest, and measures the latency on each frame.

// File: rtl/mii_stamp_pkg.sv
package mii_stamp_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef struct packed {
        logic       en;
        logic [3:0] d;
    } nib_t;

    // Advance a reflected CRC-32 by one nibble (LSB first).
    function automatic logic [31:0] crc_step_nib(input logic [31:0] c, input logic [3:0] n);
        logic [31:0] r;
        r = c ^ {28'd0, n};
        for (int i = 0; i < 4; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/stamp_lane.sv
module stamp_lane
    import mii_stamp_pkg::*;
#(
    parameter int TIME_W    = 32,
    parameter int ACC_W     = 16,
    parameter int STAMP_OFS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [15:0]               sync_type,
    input  logic [TIME_W+ACC_W-1:0]   stamp_in,
    input  logic                      in_en,
    input  logic [3:0]                in_d,
    output logic                      out_en,
    output logic [3:0]                out_d
);
    localparam int SW        = TIME_W + ACC_W;
    localparam int STAMP_NIB = SW / 4;
    localparam int WS        = 28 + 2 * STAMP_OFS;     // first stamp nibble index
    localparam int WE        = WS + STAMP_NIB;         // one past last stamp nibble
    localparam int NEED      = WE + 8;                 // nibbles needed incl. check sequence
    localparam int PIPE_D    = STAMP_NIB + 10;
    localparam int AHEAD     = PIPE_D - 9;             // tap eight nibbles ahead of the tail
    localparam int IW        = $clog2(NEED + 1) + 1;

    localparam logic [IW-1:0] IDX_TYPE_LO = IW'(24);
    localparam logic [IW-1:0] IDX_TYPE_HI = IW'(27);
    localparam logic [IW-1:0] IDX_WS      = IW'(WS);
    localparam logic [IW-1:0] IDX_WE      = IW'(WE);
    localparam logic [IW-1:0] IDX_LAST    = IW'(NEED - 1);

    typedef struct packed {
        nib_t [PIPE_D-1:0] pipe;
        logic              in_post;
        logic [IW-1:0]     in_idx;
        logic [15:0]       type_sh;
        logic              match;
        logic              long_ok;
        logic [SW-1:0]     stamp;
        logic              out_post;
        logic [IW-1:0]     out_idx;
        logic              use_st;
        logic [31:0]       crc;
        logic [3:0]        fcs_cnt;
        nib_t              o;
    } lane_st_t;

    lane_st_t      st_d, st_q;
    nib_t          tail;
    logic          ahead_en;
    logic          act, in_fcs, qual;
    logic [IW-1:0] off;
    logic [SW-1:0] stamp_sh;
    logic [31:0]   crc_sh;

    assign tail     = st_q.pipe[PIPE_D-1];
    assign ahead_en = st_q.pipe[AHEAD].en;
    assign qual     = st_q.match && st_q.long_ok;

    always_comb begin
        st_d      = st_q;
        act       = 1'b0;
        in_fcs    = 1'b0;
        off       = st_q.out_idx - IDX_WS;
        stamp_sh  = st_q.stamp >> {off, 2'b00};
        crc_sh    = (~st_q.crc) >> {st_q.fcs_cnt[2:0], 2'b00};

        st_d.pipe = {st_q.pipe[PIPE_D-2:0], in_en, in_d};

        // Input side: parse type and length, capture stamp at delimiter.
        if (in_en) begin
            if (!st_q.in_post) begin
                if (in_d == 4'hD) begin
                    st_d.in_post = 1'b1;
                    st_d.in_idx  = '0;
                    st_d.match   = 1'b0;
                    st_d.long_ok = 1'b0;
                    st_d.stamp   = stamp_in;
                end
            end else begin
                if (st_q.in_idx != '1) st_d.in_idx = st_q.in_idx + 1'b1;
                if (st_q.in_idx >= IDX_TYPE_LO && st_q.in_idx <= IDX_TYPE_HI)
                    st_d.type_sh = {in_d, st_q.type_sh[15:4]};
                if (st_q.in_idx == IDX_TYPE_HI)
                    st_d.match = ({in_d, st_q.type_sh[15:4]} == {sync_type[7:0], sync_type[15:8]});
                if (st_q.in_idx == IDX_LAST)
                    st_d.long_ok = 1'b1;
            end
        end else begin
            st_d.in_post = 1'b0;
        end

        // Output side: overwrite stamp window, regenerate check sequence.
        st_d.o = tail;
        if (tail.en) begin
            if (!st_q.out_post) begin
                if (tail.d == 4'hD) begin
                    st_d.out_post = 1'b1;
                    st_d.out_idx  = '0;
                    st_d.use_st   = 1'b0;
                    st_d.crc      = '1;
                    st_d.fcs_cnt  = '0;
                end
            end else begin
                act         = st_q.use_st || (st_q.out_idx == IDX_WS && qual);
                in_fcs      = !ahead_en;
                st_d.use_st = act;
                if (act && in_fcs) begin
                    st_d.o.d     = crc_sh[3:0];
                    st_d.fcs_cnt = st_q.fcs_cnt + 1'b1;
                end else if (act && st_q.out_idx < IDX_WE) begin
                    st_d.o.d = stamp_sh[3:0];
                end
                if (!in_fcs) st_d.crc = crc_step_nib(st_q.crc, st_d.o.d);
                if (st_q.out_idx != '1) st_d.out_idx = st_q.out_idx + 1'b1;
            end
        end else begin
            st_d.out_post = 1'b0;
            st_d.use_st   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_en = st_q.o.en;
    assign out_d  = st_q.o.d;

    // R3 / R8: rewriting is only active for a matching, long-enough frame.
    assert_stamp_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.use_st |-> (st_q.match && st_q.long_ok));

    // R6: a rewritten frame ends after exactly eight regenerated nibbles.
    assert_fcs_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tail.en && st_q.use_st) |-> (st_q.fcs_cnt == 4'd8));

    // R6: the running CRC is frozen while its value is being emitted.
    assert_crc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.use_st && st_q.out_post && tail.en && !ahead_en) |=> $stable(st_q.crc));

    // R7: outside a rewritten frame the output is the delayed input nibble.
    assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.o.en && !st_q.use_st) |-> (st_q.o.d == $past(tail.d)));

endmodule

// File: rtl/mii_stamp_inserter.sv
module mii_stamp_inserter #(
    parameter int TIME_W    = 32,
    parameter int ACC_W     = 16,
    parameter int STAMP_OFS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       sync_type,
    input  logic [TIME_W-1:0] local_time,
    input  logic [ACC_W-1:0]  local_acc,
    input  logic              mac_tx_en,
    input  logic [3:0]        mac_txd,
    output logic              phy_tx_en,
    output logic [3:0]        phy_txd,
    input  logic              phy_rx_dv,
    input  logic [3:0]        phy_rxd,
    output logic              mac_rx_dv,
    output logic [3:0]        mac_rxd
);
    logic [TIME_W+ACC_W-1:0] stamp_word;
    assign stamp_word = {local_acc, local_time};

    // R2: two identical, independent lanes.
    stamp_lane #(.TIME_W(TIME_W), .ACC_W(ACC_W), .STAMP_OFS(STAMP_OFS)) u_tx_lane (
        .clk(clk), .rst_n(rst_n), .sync_type(sync_type), .stamp_in(stamp_word),
        .in_en(mac_tx_en), .in_d(mac_txd), .out_en(phy_tx_en), .out_d(phy_txd)
    );

    stamp_lane #(.TIME_W(TIME_W), .ACC_W(ACC_W), .STAMP_OFS(STAMP_OFS)) u_rx_lane (
        .clk(clk), .rst_n(rst_n), .sync_type(sync_type), .stamp_in(stamp_word),
        .in_en(phy_rx_dv), .in_d(phy_rxd), .out_en(mac_rx_dv), .out_d(mac_rxd)
    );

endmodule

// File: tb/test_mii_stamp_inserter.sv
`timescale 1ns/1ps
module test_mii_stamp_inserter;
    localparam int LAT = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sync_type = 16'h88F7;
    logic [31:0] time_v = 32'h1234_5678;
    logic [15:0] acc_v  = 16'hA0C3;
    logic        mac_tx_en = 1'b0, phy_rx_dv = 1'b0;
    logic [3:0]  mac_txd = 4'h0, phy_rxd = 4'h0;
    logic        phy_tx_en, mac_rx_dv;
    logic [3:0]  phy_txd, mac_rxd;

    int checks = 0, errors = 0, cyc = 0;
    int tx_n = 0, rx_n = 0, tx_first = 0, rx_first = 0;
    logic [3:0] cap_tx [0:299];
    logic [3:0] cap_rx [0:299];
    logic [7:0] frm [0:127];
    logic [7:0] ex  [0:127];

    mii_stamp_inserter i_mii_stamp_inserter (
        .clk(clk), .rst_n(rst_n), .sync_type(sync_type), .local_time(time_v), .local_acc(acc_v),
        .mac_tx_en(mac_tx_en), .mac_txd(mac_txd), .phy_tx_en(phy_tx_en), .phy_txd(phy_txd),
        .phy_rx_dv(phy_rx_dv), .phy_rxd(phy_rxd), .mac_rx_dv(mac_rx_dv), .mac_rxd(mac_rxd)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (phy_tx_en) begin
            if (tx_n == 0) tx_first = cyc;
            if (tx_n < 300) cap_tx[tx_n] = phy_txd;
            tx_n++;
        end
        if (mac_rx_dv) begin
            if (rx_n == 0) rx_first = cyc;
            if (rx_n < 300) cap_rx[rx_n] = mac_rxd;
            rx_n++;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ex(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'd0, ex[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic drive(input int dir, input logic en, input logic [3:0] d);
        if (dir == 0) begin mac_tx_en = en; mac_txd = d; end
        else          begin phy_rx_dv = en; phy_rxd = d; end
    endtask

    // Send one frame of nb bytes (byte 0 through check sequence) and check the output.
    task automatic run_frame(input int dir, input int nb, input logic [15:0] ty,
                             input bit good, input bit exp_st, input string tag);
        logic [47:0] st;
        logic [31:0] c;
        logic [3:0]  nib, got;
        int in_first, n, first, other, bad_st, bad_fcs, bad_oth, byte_i;
        bad_st = 0; bad_fcs = 0; bad_oth = 0; in_first = 0; st = '0;
        for (int i = 0; i < nb; i++) frm[i] = 8'((i * 37 + 11) & 255);
        frm[12] = ty[15:8];
        frm[13] = ty[7:0];
        for (int i = 0; i < nb; i++) ex[i] = frm[i];
        c = crc_ex(nb - 4);
        for (int j = 0; j < 4; j++) frm[nb-4+j] = good ? c[8*j +: 8] : (8'hA5 ^ 8'(j));
        tx_n = 0; rx_n = 0;
        for (int k = 0; k < 16 + 2 * nb; k++) begin
            @(negedge clk);
            if (k < 15)      nib = 4'h5;
            else if (k == 15) nib = 4'hD;
            else if (k[0] == 1'b0) nib = frm[(k-16)/2][3:0];
            else             nib = frm[(k-16)/2][7:4];
            if (k == 0) in_first = cyc;
            if (k == 15) st = {acc_v, time_v};
            if (k == 16) begin time_v = time_v + 32'h0101_0101; acc_v = acc_v ^ 16'h0F0F; end
            drive(dir, 1'b1, nib);
        end
        @(negedge clk);
        drive(dir, 1'b0, 4'h0);
        repeat (40) @(negedge clk);

        for (int i = 0; i < nb; i++) ex[i] = frm[i];
        if (exp_st) begin
            for (int b = 0; b < 6; b++) ex[16+b] = st[8*b +: 8];
            c = crc_ex(nb - 4);
            for (int j = 0; j < 4; j++) ex[nb-4+j] = c[8*j +: 8];
        end

        n     = (dir == 0) ? tx_n : rx_n;
        first = (dir == 0) ? tx_first : rx_first;
        other = (dir == 0) ? rx_n : tx_n;
        check(n == 16 + 2 * nb, {tag, " R9 output nibble count"}, n, 16 + 2 * nb);
        check(other == 0, {tag, " R2 other lane stays idle"}, other, 0);
        check(first - in_first == LAT, {tag, " R9 latency"}, first - in_first, LAT);
        for (int k = 0; k < 16 + 2 * nb && k < n; k++) begin
            got = (dir == 0) ? cap_tx[k] : cap_rx[k];
            if (k < 15)      nib = 4'h5;
            else if (k == 15) nib = 4'hD;
            else if (k[0] == 1'b0) nib = ex[(k-16)/2][3:0];
            else             nib = ex[(k-16)/2][7:4];
            byte_i = (k - 16) / 2;
            if (got !== nib) begin
                if (k >= 16 && byte_i >= 16 && byte_i < 22 && byte_i < nb - 4) bad_st++;
                else if (k >= 16 && byte_i >= nb - 4) bad_fcs++;
                else bad_oth++;
            end
        end
        check(bad_st == 0,  {tag, " R4 stamp window mismatching nibbles"}, bad_st, 0);
        check(bad_fcs == 0, {tag, " R6 check sequence mismatching nibbles"}, bad_fcs, 0);
        check(bad_oth == 0, {tag, " R5 other mismatching nibbles"}, bad_oth, 0);
    endtask

    task automatic test_reset_r1;
        repeat (3) @(negedge clk);
        check(phy_tx_en == 1'b0 && mac_rx_dv == 1'b0, "R1 enables low in reset", int'(phy_tx_en | mac_rx_dv), 0);
        check(phy_txd == 4'h0 && mac_rxd == 4'h0, "R1 data zero in reset", int'(phy_txd | mac_rxd), 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check(tx_n == 0 && rx_n == 0 && phy_txd == 4'h0, "R1 idle after reset", tx_n + rx_n, 0);
    endtask

    task automatic test_tx_sync;
        run_frame(0, 64, 16'h88F7, 1'b1, 1'b1, "R3 tx sync frame");
    endtask

    task automatic test_rx_sync;
        run_frame(1, 60, 16'h88F7, 1'b1, 1'b1, "R2 rx sync frame");
    endtask

    task automatic test_other_type_r7;
        run_frame(0, 64, 16'h0800, 1'b1, 1'b0, "R7 tx other type");
        run_frame(1, 48, 16'h88F6, 1'b0, 1'b0, "R7 rx other type bad check sequence");
    endtask

    task automatic test_length_r8;
        run_frame(0, 22, 16'h88F7, 1'b1, 1'b0, "R8 short matching frame");
        run_frame(0, 25, 16'h88F7, 1'b1, 1'b0, "R8 one byte under limit");
        run_frame(0, 26, 16'h88F7, 1'b1, 1'b1, "R8 exact limit stamped");
        run_frame(1, 26, 16'h88F7, 1'b0, 1'b1, "R8 rx exact limit bad input check");
    endtask

    task automatic test_retype_r10;
        @(negedge clk);
        sync_type = 16'h1234;
        repeat (5) @(negedge clk);
        run_frame(0, 64, 16'h88F7, 1'b1, 1'b0, "R10 old type after change");
        run_frame(1, 64, 16'h1234, 1'b1, 1'b1, "R10 new type after change");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset_r1();
        test_tx_sync();
        test_rx_sync();
        test_other_type_r7();
        test_length_r8();
        test_retype_r10();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule